// File: doc/BRIEF.md
# Peripheral I/O Register Bank

This block is the control and status register file of a small handheld-style system. A bus master writes bytes, halfwords or words into it, and reads halfwords back. Most locations simply hold what was written. Some locations have their own access rule: interrupt flags are cleared by writing ones, the key input location reads the pressed-key vector inverted, timer counter locations read the live count and turn writes into reload requests, DMA count words cannot be read back, and DMA address halves are joined into 32-bit updates.

Side effects leave the bank as registered, one-cycle strobes with a channel index and a data word. The strobes go to the timer unit, the DMA engine and the interrupt controller. A halt request goes to the processor. The timers and the DMA engine are not part of this block. They appear only as those strobes, plus the live counter input. Interrupt sources set flag bits through a raise vector.

Writes use a valid/ready handshake. Ready is low only during reset and never drops afterwards, so the bank never applies back-pressure. A write is taken on every clock edge where valid and ready are both high. The read port is a plain combinational lookup by halfword index.

Top module: `io_regbank`

## Requirements
- R1: After reset the display control halfword (byte 0x000) reads 0x0080, the key location (byte 0x040) holds 0x3FF, every other stored location reads 0, `wr_ready` is 1 and no strobe is active.
- R2: A read of the key location returns 0x3FF XOR `keys_pressed` (bit i high means key i is pressed), so a pressed key reads as 0 and bits 15:10 read 0.
- R3: The interrupt flag halfword (byte 0x102) sets bit i in the cycle after `irq_raise[i]` is high. A write to it clears each stored bit where the written value has a 1, and leaves bits written as 0 unchanged.
- R4: Timer k's control halfword (byte 0x080+4k+2) stores the written value AND 0x00C7. The write raises `tmr_ctl_stb` with `tmr_ch`=k and that masked value.
- R5: A write to timer k's counter halfword (byte 0x080+4k) raises `tmr_reload_stb` with `tmr_ch`=k and the written value, and stores nothing. A read of that halfword returns `tmr_count[16k+15:16k]`.
- R6: DMA channel k's count halfword (byte 0x0C0+12k+8) always reads 0. A write to it, or to the control halfword at +10, raises `dma_ctl_stb` with `dma_ch`=k and {control, count} as a 32-bit value.
- R7: `wr_size`=0 is a byte write of `wr_data[7:0]`. It goes to the upper byte when address bit 0 is 1 and to the lower byte otherwise. The other byte keeps its stored value, and the merged halfword then follows that halfword's normal rule.
- R8: A byte write to byte 0x111 stores nothing. It raises `halt_req` for one cycle when data bit 7 is 0 and does nothing when bit 7 is 1.
- R9: A halfword write to either half of DMA channel k's source address (+0/+2) or destination address (+4/+6) raises `dma_addr_stb`. The strobe carries `dma_ch`=k, `dma_addr_is_dst` and a 32-bit value made of the new half and the stored other half. A word write supplies both halves.
- R10: `wr_size`=2 is a word write. Address bits 1:0 are ignored. `wr_data[15:0]` is handled as a halfword write to the low half and `wr_data[31:16]` as one to the high half, both in the same cycle.
- R11: A write to the interrupt enable halfword (byte 0x100) raises `irq_ie_stb`, and a write to the master enable halfword (byte 0x108) raises `irq_ime_stb`. Each carries the stored value on `irq_upd_val`.
- R12: Any other location, including an unmapped one, stores the written halfword unchanged and reads it back.
- R13: Every strobe appears in the cycle after the accepting edge and lasts one cycle per accepted write. A single write never raises strobes for two different units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write accepted when high with wr_valid |
| wr_addr | input | ADDR_W | Write byte address |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word |
| wr_data | input | 32 | Write data, right-aligned |
| rd_hword | input | ADDR_W-1 | Read halfword index (byte address / 2) |
| rd_data | output | 16 | Read data |
| keys_pressed | input | KEY_W | Active-high pressed-key vector |
| tmr_count | input | 16*N_TMR | Live timer counts, timer k in bits 16k+15:16k |
| irq_raise | input | 16 | Interrupt flag set pulses |
| tmr_ch | output | TCH_W | Timer index for timer strobes |
| tmr_reload_stb | output | 1 | Timer reload strobe |
| tmr_reload_val | output | 16 | Reload value |
| tmr_ctl_stb | output | 1 | Timer control update strobe |
| tmr_ctl_val | output | 16 | Masked control value |
| dma_ch | output | DCH_W | DMA channel for DMA strobes |
| dma_addr_stb | output | 1 | 32-bit DMA address update strobe |
| dma_addr_is_dst | output | 1 | 1 destination, 0 source |
| dma_addr_val | output | 32 | Combined address |
| dma_ctl_stb | output | 1 | DMA count/control update strobe |
| dma_ctl_val | output | 32 | {control, count} |
| irq_ie_stb | output | 1 | Interrupt enable update strobe |
| irq_ime_stb | output | 1 | Master enable update strobe |
| irq_upd_val | output | 16 | Value for the interrupt strobes |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The bench uses the default parameters: a 9-bit address space, four timers, four DMA channels and a 10-bit key vector. With these values the highest channels (timer 3, DMA channel 3) sit at the upper edge of their decoded regions. The index encoding is therefore exercised at its top value, next to the first and middle channels. The full key width is inverted on readback, an unmapped location near the top of the space is reachable, and word writes can span a timer's counter and control halves in one cycle.

// File: rtl/io_regbank_pkg.sv
package io_regbank_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } wr_size_e;

  typedef enum logic [2:0] {
    PC_PLAIN,
    PC_TMR,
    PC_DMA_SRC,
    PC_DMA_DST,
    PC_DMA_CNT,
    PC_IRQ,
    PC_IME
  } pair_cls_e;

  // byte offsets of the special locations
  localparam int DISP_ADDR  = 'h000;
  localparam int KEYS_ADDR  = 'h040;
  localparam int TMR_BASE   = 'h080;
  localparam int TMR_STRIDE = 4;
  localparam int DMA_BASE   = 'h0C0;
  localparam int DMA_STRIDE = 12;
  localparam int IRQ_ADDR   = 'h100;  // enable low half, flags high half
  localparam int FLAG_ADDR  = 'h102;
  localparam int IME_ADDR   = 'h108;
  localparam int HALT_ADDR  = 'h111;

  localparam logic [15:0] DISP_RESET   = 16'h0080;
  localparam logic [15:0] TMR_CTL_MASK = 16'h00C7;

endpackage

// File: rtl/io_lane_merge.sv
module io_lane_merge
  import io_regbank_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int PW = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  wr_size_e          size,
  input  logic [31:0]       data,
  input  logic [15:0]       cur_lo,
  input  logic [15:0]       cur_hi,
  output logic [PW-1:0]     pair,
  output logic              we_lo,
  output logic              we_hi,
  output logic [15:0]       new_lo,
  output logic [15:0]       new_hi,
  output logic              halt_hit
);

  logic [15:0] byte_base;
  logic [15:0] byte_merged;

  assign pair     = addr[ADDR_W-1:2];
  assign halt_hit = (size == SZ_BYTE) && (addr == ADDR_W'(HALT_ADDR));

  always_comb begin
    byte_base   = addr[1] ? cur_hi : cur_lo;
    byte_merged = addr[0] ? {data[7:0], byte_base[7:0]}
                          : {byte_base[15:8], data[7:0]};
  end

  always_comb begin
    we_lo  = 1'b0;
    we_hi  = 1'b0;
    new_lo = cur_lo;
    new_hi = cur_hi;
    unique case (size)
      SZ_BYTE: begin
        if (!halt_hit) begin
          we_lo = !addr[1];
          we_hi = addr[1];
        end
        if (addr[1]) new_hi = byte_merged;
        else         new_lo = byte_merged;
      end
      SZ_HALF: begin
        we_lo = !addr[1];
        we_hi = addr[1];
        if (addr[1]) new_hi = data[15:0];
        else         new_lo = data[15:0];
      end
      SZ_WORD: begin
        we_lo  = 1'b1;
        we_hi  = 1'b1;
        new_lo = data[15:0];
        new_hi = data[31:16];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/io_pair_class.sv
module io_pair_class
  import io_regbank_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int N_TMR  = 4,
  parameter int N_DMA  = 4,
  localparam int PW    = ADDR_W - 2,
  localparam int TCH_W = (N_TMR > 1) ? $clog2(N_TMR) : 1,
  localparam int DCH_W = (N_DMA > 1) ? $clog2(N_DMA) : 1
) (
  input  logic [PW-1:0]    pair,
  output pair_cls_e        cls,
  output logic [TCH_W-1:0] tch,
  output logic [DCH_W-1:0] dch
);

  logic [N_TMR-1:0] tmr_hit;
  logic [N_DMA-1:0] src_hit, dst_hit, cnt_hit;

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    assign tmr_hit[k] = (pair == PW'((TMR_BASE + k*TMR_STRIDE) >> 2));
  end

  for (genvar k = 0; k < N_DMA; k++) begin : g_dma
    localparam int P0 = (DMA_BASE + k*DMA_STRIDE) >> 2;
    assign src_hit[k] = (pair == PW'(P0));
    assign dst_hit[k] = (pair == PW'(P0 + 1));
    assign cnt_hit[k] = (pair == PW'(P0 + 2));
  end

  always_comb begin
    cls = PC_PLAIN;
    tch = '0;
    dch = '0;
    for (int k = 0; k < N_TMR; k++) begin
      if (tmr_hit[k]) begin
        cls = PC_TMR;
        tch = TCH_W'(k);
      end
    end
    for (int k = 0; k < N_DMA; k++) begin
      if (src_hit[k]) begin cls = PC_DMA_SRC; dch = DCH_W'(k); end
      if (dst_hit[k]) begin cls = PC_DMA_DST; dch = DCH_W'(k); end
      if (cnt_hit[k]) begin cls = PC_DMA_CNT; dch = DCH_W'(k); end
    end
    if (pair == PW'(IRQ_ADDR >> 2)) cls = PC_IRQ;
    if (pair == PW'(IME_ADDR >> 2)) cls = PC_IME;
  end

endmodule

// File: rtl/io_reg_store.sv
module io_reg_store
  import io_regbank_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int KEY_W  = 10,
  localparam int PW    = ADDR_W - 2,
  localparam int HW    = ADDR_W - 1,
  localparam int NHW   = 1 << HW,
  localparam int FLAG_IDX = FLAG_ADDR >> 1,
  localparam logic [15:0] KEY_MASK = 16'((1 << KEY_W) - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pair,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [15:0]   val_lo,
  input  logic [15:0]   val_hi,
  input  logic          flag_clr,
  input  logic [15:0]   flag_clr_mask,
  input  logic [15:0]   irq_raise,
  input  logic [HW-1:0] rd_idx,
  output logic [15:0]   cur_lo,
  output logic [15:0]   cur_hi,
  output logic [15:0]   rd_val
);

  logic [15:0] mem_q [NHW];
  logic        started_q;

  assign cur_lo = mem_q[{pair, 1'b0}];
  assign cur_hi = mem_q[{pair, 1'b1}];
  assign rd_val = mem_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NHW; i++) begin
        if (i == (DISP_ADDR >> 1))      mem_q[i] <= DISP_RESET;
        else if (i == (KEYS_ADDR >> 1)) mem_q[i] <= KEY_MASK;
        else                            mem_q[i] <= '0;
      end
    end else begin
      if (we_lo) mem_q[{pair, 1'b0}] <= val_lo;
      if (we_hi) mem_q[{pair, 1'b1}] <= val_hi;
      // flags: set by sources, cleared by ones written; set wins
      mem_q[FLAG_IDX] <= (mem_q[FLAG_IDX] & ~(flag_clr ? flag_clr_mask : 16'h0))
                         | irq_raise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  // R3: a flag bit only rises when its source raised it
  assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    ((mem_q[FLAG_IDX] & ~$past(mem_q[FLAG_IDX])) & ~$past(irq_raise)) == 16'h0);

endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
  import io_regbank_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int N_TMR  = 4,
  parameter int N_DMA  = 4,
  parameter int KEY_W  = 10,
  localparam int HW    = ADDR_W - 1,
  localparam logic [15:0] KEY_MASK = 16'((1 << KEY_W) - 1)
) (
  input  logic [HW-1:0]        rd_idx,
  input  logic [15:0]          stored,
  input  logic [KEY_W-1:0]     keys_pressed,
  input  logic [16*N_TMR-1:0]  tmr_count,
  output logic [15:0]          rd_data
);

  logic [N_TMR-1:0] cnt_sel;
  logic [N_DMA-1:0] wo_sel;
  logic             key_sel;

  assign key_sel = (rd_idx == HW'(KEYS_ADDR >> 1));

  for (genvar k = 0; k < N_TMR; k++) begin : g_tcnt
    assign cnt_sel[k] = (rd_idx == HW'((TMR_BASE + k*TMR_STRIDE) >> 1));
  end

  for (genvar k = 0; k < N_DMA; k++) begin : g_wo
    assign wo_sel[k] = (rd_idx == HW'((DMA_BASE + k*DMA_STRIDE + 8) >> 1));
  end

  always_comb begin
    rd_data = stored;
    if (key_sel) rd_data = KEY_MASK ^ 16'(keys_pressed);
    for (int k = 0; k < N_TMR; k++) begin
      if (cnt_sel[k]) rd_data = tmr_count[k*16 +: 16];
    end
    if (|wo_sel) rd_data = 16'h0;
  end

endmodule

// File: rtl/io_regbank.sv
module io_regbank
  import io_regbank_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int N_TMR  = 4,
  parameter int N_DMA  = 4,
  parameter int KEY_W  = 10,
  localparam int PW    = ADDR_W - 2,
  localparam int HW    = ADDR_W - 1,
  localparam int TCH_W = (N_TMR > 1) ? $clog2(N_TMR) : 1,
  localparam int DCH_W = (N_DMA > 1) ? $clog2(N_DMA) : 1,
  localparam logic [15:0] KEY_MASK = 16'((1 << KEY_W) - 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [1:0]           wr_size,
  input  logic [31:0]          wr_data,
  input  logic [HW-1:0]        rd_hword,
  output logic [15:0]          rd_data,
  input  logic [KEY_W-1:0]     keys_pressed,
  input  logic [16*N_TMR-1:0]  tmr_count,
  input  logic [15:0]          irq_raise,
  output logic [TCH_W-1:0]     tmr_ch,
  output logic                 tmr_reload_stb,
  output logic [15:0]          tmr_reload_val,
  output logic                 tmr_ctl_stb,
  output logic [15:0]          tmr_ctl_val,
  output logic [DCH_W-1:0]     dma_ch,
  output logic                 dma_addr_stb,
  output logic                 dma_addr_is_dst,
  output logic [31:0]          dma_addr_val,
  output logic                 dma_ctl_stb,
  output logic [31:0]          dma_ctl_val,
  output logic                 irq_ie_stb,
  output logic                 irq_ime_stb,
  output logic [15:0]          irq_upd_val,
  output logic                 halt_req
);

  logic            fire;
  logic [PW-1:0]   pair;
  logic            we_lo, we_hi, halt_hit;
  logic [15:0]     new_lo, new_hi, cur_lo, cur_hi, stored_rd;
  pair_cls_e       cls;
  logic [TCH_W-1:0] tch;
  logic [DCH_W-1:0] dch;

  logic        st_we_lo, st_we_hi, flag_clr;
  logic [15:0] st_hi;
  logic [15:0] lo_eff, hi_eff;
  logic        t_rel, t_ctl, d_addr, d_ctl, ie_upd, ime_upd, halt_d;
  logic        started_q;

  assign fire = wr_valid && wr_ready;

  io_lane_merge #(.ADDR_W(ADDR_W)) u_merge (
    .addr(wr_addr), .size(wr_size_e'(wr_size)), .data(wr_data),
    .cur_lo(cur_lo), .cur_hi(cur_hi), .pair(pair),
    .we_lo(we_lo), .we_hi(we_hi), .new_lo(new_lo), .new_hi(new_hi),
    .halt_hit(halt_hit)
  );

  io_pair_class #(.ADDR_W(ADDR_W), .N_TMR(N_TMR), .N_DMA(N_DMA)) u_class (
    .pair(pair), .cls(cls), .tch(tch), .dch(dch)
  );

  always_comb begin
    lo_eff   = we_lo ? new_lo : cur_lo;
    hi_eff   = we_hi ? new_hi : cur_hi;
    st_we_lo = fire && we_lo;
    st_we_hi = fire && we_hi;
    st_hi    = new_hi;
    flag_clr = 1'b0;
    t_rel    = 1'b0;
    t_ctl    = 1'b0;
    d_addr   = 1'b0;
    d_ctl    = 1'b0;
    ie_upd   = 1'b0;
    ime_upd  = 1'b0;
    halt_d   = fire && halt_hit && !wr_data[7];
    unique case (cls)
      PC_TMR: begin
        st_we_lo = 1'b0;
        st_hi    = new_hi & TMR_CTL_MASK;
        t_rel    = fire && we_lo;
        t_ctl    = fire && we_hi;
      end
      PC_DMA_SRC, PC_DMA_DST: d_addr = fire && (we_lo || we_hi);
      PC_DMA_CNT:             d_ctl  = fire && (we_lo || we_hi);
      PC_IRQ: begin
        st_we_hi = 1'b0;
        flag_clr = fire && we_hi;
        ie_upd   = fire && we_lo;
      end
      PC_IME:  ime_upd = fire && we_lo;
      default: ;
    endcase
  end

  io_reg_store #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .pair(pair),
    .we_lo(st_we_lo), .we_hi(st_we_hi), .val_lo(new_lo), .val_hi(st_hi),
    .flag_clr(flag_clr), .flag_clr_mask(new_hi), .irq_raise(irq_raise),
    .rd_idx(rd_hword), .cur_lo(cur_lo), .cur_hi(cur_hi), .rd_val(stored_rd)
  );

  io_read_mux #(.ADDR_W(ADDR_W), .N_TMR(N_TMR), .N_DMA(N_DMA), .KEY_W(KEY_W)) u_rd (
    .rd_idx(rd_hword), .stored(stored_rd), .keys_pressed(keys_pressed),
    .tmr_count(tmr_count), .rd_data(rd_data)
  );

  // strobe and data registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ready        <= 1'b0;
      started_q       <= 1'b0;
      tmr_reload_stb  <= 1'b0;
      tmr_ctl_stb     <= 1'b0;
      dma_addr_stb    <= 1'b0;
      dma_ctl_stb     <= 1'b0;
      irq_ie_stb      <= 1'b0;
      irq_ime_stb     <= 1'b0;
      halt_req        <= 1'b0;
      tmr_ch          <= '0;
      tmr_reload_val  <= '0;
      tmr_ctl_val     <= '0;
      dma_ch          <= '0;
      dma_addr_is_dst <= 1'b0;
      dma_addr_val    <= '0;
      dma_ctl_val     <= '0;
      irq_upd_val     <= '0;
    end else begin
      wr_ready       <= 1'b1;
      started_q      <= 1'b1;
      tmr_reload_stb <= t_rel;
      tmr_ctl_stb    <= t_ctl;
      dma_addr_stb   <= d_addr;
      dma_ctl_stb    <= d_ctl;
      irq_ie_stb     <= ie_upd;
      irq_ime_stb    <= ime_upd;
      halt_req       <= halt_d;
      if (t_rel || t_ctl) tmr_ch <= tch;
      if (t_rel) tmr_reload_val <= new_lo;
      if (t_ctl) tmr_ctl_val    <= st_hi;
      if (d_addr || d_ctl) dma_ch <= dch;
      if (d_addr) begin
        dma_addr_is_dst <= (cls == PC_DMA_DST);
        dma_addr_val    <= {hi_eff, lo_eff};
      end
      if (d_ctl) dma_ctl_val <= {hi_eff, lo_eff};
      if (ie_upd || ime_upd) irq_upd_val <= new_lo;
    end
  end

  // R8: a halt request only follows a halt byte with bit 7 clear
  assert_halt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    halt_req |-> $past(wr_valid && wr_ready && wr_size == 2'd0
                       && wr_addr == ADDR_W'(HALT_ADDR) && !wr_data[7]));

  // R13: one write never reaches two units
  assert_unit_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_reload_stb || tmr_ctl_stb, dma_addr_stb, dma_ctl_stb,
              irq_ie_stb, irq_ime_stb, halt_req}));

  // R4: forwarded timer control never carries masked-off bits
  assert_tmr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ctl_stb |-> ((tmr_ctl_val & ~TMR_CTL_MASK) == 16'h0));

  // R9: an address strobe is caused by an accepted write
  assert_dma_cause_R9: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    dma_addr_stb |-> $past(wr_valid && wr_ready));

  // R2: key readback never exceeds the key width
  assert_key_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hword == HW'(KEYS_ADDR >> 1)) |-> ((rd_data & ~KEY_MASK) == 16'h0));

endmodule

// File: tb/io_regbank_tb_top.sv
`timescale 1ns/1ps
module io_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [8:0]  wr_addr = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_hword = '0;
  logic [15:0] rd_data;
  logic [9:0]  keys_pressed = '0;
  logic [63:0] tmr_count = {16'h3333, 16'h2222, 16'hBEEF, 16'h0000};
  logic [15:0] irq_raise = '0;
  logic [1:0]  tmr_ch;
  logic        tmr_reload_stb, tmr_ctl_stb;
  logic [15:0] tmr_reload_val, tmr_ctl_val;
  logic [1:0]  dma_ch;
  logic        dma_addr_stb, dma_addr_is_dst, dma_ctl_stb;
  logic [31:0] dma_addr_val, dma_ctl_val;
  logic        irq_ie_stb, irq_ime_stb, halt_req;
  logic [15:0] irq_upd_val;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  io_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .rd_hword(rd_hword), .rd_data(rd_data), .keys_pressed(keys_pressed),
    .tmr_count(tmr_count), .irq_raise(irq_raise), .tmr_ch(tmr_ch),
    .tmr_reload_stb(tmr_reload_stb), .tmr_reload_val(tmr_reload_val),
    .tmr_ctl_stb(tmr_ctl_stb), .tmr_ctl_val(tmr_ctl_val), .dma_ch(dma_ch),
    .dma_addr_stb(dma_addr_stb), .dma_addr_is_dst(dma_addr_is_dst),
    .dma_addr_val(dma_addr_val), .dma_ctl_stb(dma_ctl_stb),
    .dma_ctl_val(dma_ctl_val), .irq_ie_stb(irq_ie_stb),
    .irq_ime_stb(irq_ime_stb), .irq_upd_val(irq_upd_val), .halt_req(halt_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge (strobes visible)
  task automatic wr(input logic [8:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] v);
    rd_hword = a[8:1];
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(9'h000, v); chk("R1 display reset", v, 32'h0080);
    rd(9'h040, v); chk("R1 key reset", v, 32'h03FF);
    rd(9'h100, v); chk("R1 enable reset", v, 32'h0);
    chk("R1 ready", wr_ready, 1);
    chk("R1 no strobes", {tmr_reload_stb, tmr_ctl_stb, dma_addr_stb, dma_ctl_stb,
                          irq_ie_stb, irq_ime_stb, halt_req}, 0);
  endtask

  task automatic t_keys();
    logic [15:0] v;
    keys_pressed = 10'h005; rd(9'h040, v); chk("R2 keys 005", v, 32'h03FA);
    keys_pressed = 10'h3FF; rd(9'h040, v); chk("R2 keys all", v, 32'h0000);
    keys_pressed = 10'h200; rd(9'h040, v); chk("R2 key 9", v, 32'h01FF);
    keys_pressed = '0;
  endtask

  task automatic t_flags();
    logic [15:0] v;
    @(negedge clk); irq_raise = 16'h00A5;
    @(negedge clk); irq_raise = 16'h0;
    rd(9'h102, v); chk("R3 raise", v, 32'h00A5);
    wr(9'h102, 2'd1, 32'h0021);
    rd(9'h102, v); chk("R3 write-one clear", v, 32'h0084);
  endtask

  task automatic t_tmr_ctl();
    logic [15:0] v;
    wr(9'h08E, 2'd1, 32'hFFFF);
    chk("R4 ctl strobe", tmr_ctl_stb, 1);
    chk("R4 ctl ch", tmr_ch, 3);
    chk("R4 ctl val", tmr_ctl_val, 32'h00C7);
    rd(9'h08E, v); chk("R4 ctl stored", v, 32'h00C7);
    @(negedge clk); chk("R13 ctl strobe width", tmr_ctl_stb, 0);
  endtask

  task automatic t_tmr_reload();
    logic [15:0] v;
    wr(9'h084, 2'd1, 32'h1234);
    chk("R5 reload strobe", tmr_reload_stb, 1);
    chk("R5 reload ch", tmr_ch, 1);
    chk("R5 reload val", tmr_reload_val, 32'h1234);
    chk("R5 no ctl strobe", tmr_ctl_stb, 0);
    rd(9'h084, v); chk("R5 live count", v, 32'hBEEF);
  endtask

  task automatic t_dma_cnt();
    logic [15:0] v;
    wr(9'h0E0, 2'd1, 32'h0010);
    chk("R6 ctl strobe", dma_ctl_stb, 1);
    chk("R6 ch", dma_ch, 2);
    chk("R6 val lo", dma_ctl_val, 32'h0000_0010);
    rd(9'h0E0, v); chk("R6 count reads zero", v, 32'h0);
    wr(9'h0E2, 2'd1, 32'h8000);
    chk("R6 val joined", dma_ctl_val, 32'h8000_0010);
    rd(9'h0E2, v); chk("R6 control readback", v, 32'h8000);
  endtask

  task automatic t_bytes();
    logic [15:0] v;
    wr(9'h020, 2'd1, 32'h1122);
    wr(9'h021, 2'd0, 32'h00AB);
    rd(9'h020, v); chk("R7 upper byte", v, 32'hAB22);
    wr(9'h020, 2'd0, 32'h00CD);
    rd(9'h020, v); chk("R7 lower byte", v, 32'hABCD);
  endtask

  task automatic t_halt();
    logic [15:0] v;
    wr(9'h111, 2'd0, 32'h0000);
    chk("R8 halt pulse", halt_req, 1);
    @(negedge clk); chk("R8 halt one cycle", halt_req, 0);
    wr(9'h111, 2'd0, 32'h0080);
    chk("R8 stop ignored", halt_req, 0);
    rd(9'h110, v); chk("R8 not stored", v, 32'h0);
  endtask

  task automatic t_dma_addr();
    logic [15:0] v;
    wr(9'h0C0, 2'd1, 32'h5678);
    chk("R9 src strobe", dma_addr_stb, 1);
    chk("R9 src ch", dma_ch, 0);
    chk("R9 src kind", dma_addr_is_dst, 0);
    chk("R9 src low only", dma_addr_val, 32'h0000_5678);
    wr(9'h0C2, 2'd1, 32'h1234);
    chk("R9 src joined", dma_addr_val, 32'h1234_5678);
    wr(9'h0E8, 2'd2, 32'hCAFE_F00D);
    chk("R9 dst ch", dma_ch, 3);
    chk("R9 dst kind", dma_addr_is_dst, 1);
    chk("R9 dst word", dma_addr_val, 32'hCAFE_F00D);
    rd(9'h0EA, v); chk("R9 dst high stored", v, 32'hCAFE);
  endtask

  task automatic t_word();
    logic [15:0] v;
    wr(9'h030, 2'd2, 32'hDEAD_BEEF);
    rd(9'h030, v); chk("R10 low half", v, 32'hBEEF);
    rd(9'h032, v); chk("R10 high half", v, 32'hDEAD);
    wr(9'h088, 2'd2, 32'h00FF_4321);
    chk("R10 reload in word", {tmr_reload_stb, tmr_reload_val}, {1'b1, 16'h4321});
    chk("R10 ctl in word", {tmr_ctl_stb, tmr_ctl_val}, {1'b1, 16'h00C7});
    chk("R10 timer ch", tmr_ch, 2);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(9'h100, 2'd2, 32'hFFFF_0077);
    chk("R11 enable strobe", irq_ie_stb, 1);
    chk("R11 enable value", irq_upd_val, 32'h0077);
    rd(9'h102, v); chk("R3 word clears all", v, 32'h0);
    wr(9'h108, 2'd1, 32'h0001);
    chk("R11 master strobe", irq_ime_stb, 1);
    chk("R11 master value", irq_upd_val, 32'h0001);
    rd(9'h108, v); chk("R11 master stored", v, 32'h0001);
  endtask

  task automatic t_plain();
    logic [15:0] v;
    wr(9'h1F0, 2'd1, 32'h5A5A);
    rd(9'h1F0, v); chk("R12 unmapped", v, 32'h5A5A);
    chk("R13 no strobe plain", {tmr_reload_stb, tmr_ctl_stb, dma_addr_stb,
                                dma_ctl_stb, irq_ie_stb, irq_ime_stb, halt_req}, 0);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_keys();
    t_flags();
    t_tmr_ctl();
    t_tmr_reload();
    t_dma_cnt();
    t_bytes();
    t_halt();
    t_dma_addr();
    t_word();
    t_irq();
    t_plain();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule